// File: doc/BRIEF.md
# Timer match trigger generator

This block watches a free-running timer count and raises one external trigger line. It compares the count against six per-channel compare values and against the counter's initial load value. Any enabled comparison that is equal produces a trigger pulse. A single 32-bit control register sets which comparisons are enabled. The same register holds a sticky flag that records that a channel trigger has occurred since software last acknowledged it.

Software acknowledges the flag with a two-step handshake. It first reads the register while the flag is set, which arms the clear. A later write of 0 to the flag bit then clears the flag. Any channel trigger that lands inside that window cancels the pending clear, so a trigger that software has not yet seen is never lost. The counter, the compare registers and any bus bridge sit outside this block; their values arrive on plain input ports.

Top module: `trig_match_gen`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `trig_out` is 0.
- R2: Register bits [5:0] enable the channels in this order: bit 0 channel 2, bit 1 channel 3, bit 2 channel 4, bit 3 channel 5, bit 4 channel 0, bit 5 channel 1. A channel whose enable is set and whose compare value equals `cnt_val` in cycle t drives `trig_out` high in cycle t+1. A channel whose enable is clear has no effect.
- R3: Register bit 6 enables the initialization trigger. When bit 6 is set and `cnt_val` equals `init_val` in cycle t, `trig_out` is high in cycle t+1. This trigger does not set the flag.
- R4: In each cycle, `trig_out` equals the OR of all enabled matches of the previous cycle. Several matches in the same cycle give a single high cycle.
- R5: Register bit 7 is the flag. Any channel trigger in cycle t sets the flag, and the flag reads 1 from cycle t+1.
- R6: A read (`reg_rd`) while the flag is 1 arms the clear. A later write with `reg_wdata[7]` = 0 then clears the flag from the next cycle.
- R7: A write with `reg_wdata[7]` = 1 never changes the flag. A write of 0 that has no armed read before it leaves the flag set.
- R8: Every write removes the armed state, whatever value it writes. After a read, a write of 1 to bit 7, and then a write of 0, the flag is still set.
- R9: A channel trigger after the arming read and before the write removes the armed state, so that write leaves the flag set.
- R10: A clearing write in the same cycle as a channel trigger leaves the flag set.
- R11: A write loads `reg_wdata[6:0]` into the enables, and they take effect from the next cycle. Bits 31:8 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Current timer count |
| init_val | input | CNT_W | Counter initial load value |
| cmp_vals | input | 6*CNT_W | Channel compare values; channel k sits in bits [k*CNT_W +: CNT_W] |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data: flag, init enable and channel enables |
| trig_out | output | 1 | Single-cycle trigger pulse |

## Verification
The flag logic has two operations that can land in the same cycle: the hardware setting the flag on a channel match, and a software write that completes the clear handshake. The bench forces this collision in two ways. In one, it points the count at an enabled compare value in the very cycle it issues the clearing write. In the other, it puts the match between the arming read and the write. In both cases the flag must still read 1 on the next cycle. A long random phase then mixes reads, writes and matches freely. Each clock, a behavioural model judges both collisions again.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NUM_CH      = 6;
  localparam int REG_W       = 32;
  localparam int CTRL_W      = 8;
  localparam int EN_W        = 7;
  localparam int FLAG_BIT    = 7;
  localparam int INIT_EN_BIT = 6;

  // Position of a channel's enable inside the control byte.
  function automatic int ch_en_pos(input int ch);
    return (ch < 2) ? ch + 4 : ch - 2;
  endfunction

  // Reorders the packed enable bits into channel order.
  function automatic logic [NUM_CH-1:0] gather_ch_en(input logic [EN_W-1:0] en);
    logic [NUM_CH-1:0] v;
    for (int i = 0; i < NUM_CH; i++) v[i] = en[ch_en_pos(i)];
    return v;
  endfunction
endpackage

// File: rtl/trig_match.sv
module trig_match import trig_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0]        cnt_val,
  input  logic [CNT_W-1:0]        init_val,
  input  logic [NUM_CH*CNT_W-1:0] cmp_vals,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic                    init_en,
  output logic [NUM_CH-1:0]       ch_hit_vec,
  output logic                    ch_hit,
  output logic                    init_hit,
  output logic                    any_hit
);
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic [CNT_W-1:0] cmp_one;
      assign cmp_one       = cmp_vals[g*CNT_W +: CNT_W];
      assign ch_hit_vec[g] = ch_en[g] && (cnt_val == cmp_one);
    end
  endgenerate

  assign ch_hit   = |ch_hit_vec;
  assign init_hit = init_en && (cnt_val == init_val);
  assign any_hit  = ch_hit || init_hit;
endmodule

// File: rtl/trig_flag_ctl.sv
module trig_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_hit,
  input  logic reg_rd,
  input  logic reg_wr,
  input  logic wr_flag_bit,
  output logic flag_q,
  output logic armed_q,
  output logic clr_evt
);
  logic arm_evt;

  assign arm_evt = reg_rd && flag_q;
  assign clr_evt = reg_wr && armed_q && !wr_flag_bit && !ch_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (ch_hit)       flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;

      if (ch_hit || reg_wr) armed_q <= 1'b0;
      else if (arm_evt)     armed_q <= 1'b1;
    end
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_hit |=> flag_q);
  // R7
  no_clear_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && reg_wr && wr_flag_bit) |=> flag_q);
  // R7
  clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q) |=> flag_q);
  // R8
  arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !armed_q);
  // R9
  hit_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_hit |=> !armed_q);
  // R6
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && reg_wr && !wr_flag_bit && !ch_hit) |=> !flag_q);
endmodule

// File: rtl/trig_match_gen.sv
module trig_match_gen import trig_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        cnt_val,
  input  logic [CNT_W-1:0]        init_val,
  input  logic [NUM_CH*CNT_W-1:0] cmp_vals,
  input  logic                    reg_rd,
  input  logic                    reg_wr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  output logic                    trig_out
);
  localparam int RSV_W = REG_W - CTRL_W;

  logic [EN_W-1:0]   en_q;
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] ch_hit_vec;
  logic              ch_hit, init_hit, any_hit;
  logic              flag_q, armed_q, clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (reg_wr) en_q <= reg_wdata[EN_W-1:0];
  end

  assign ch_en = gather_ch_en(en_q);

  trig_match #(.CNT_W(CNT_W)) u_match (
    .cnt_val    (cnt_val),
    .init_val   (init_val),
    .cmp_vals   (cmp_vals),
    .ch_en      (ch_en),
    .init_en    (en_q[INIT_EN_BIT]),
    .ch_hit_vec (ch_hit_vec),
    .ch_hit     (ch_hit),
    .init_hit   (init_hit),
    .any_hit    (any_hit)
  );

  trig_flag_ctl u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_hit      (ch_hit),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .wr_flag_bit (reg_wdata[FLAG_BIT]),
    .flag_q      (flag_q),
    .armed_q     (armed_q),
    .clr_evt     (clr_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_out <= 1'b0;
    else        trig_out <= any_hit;
  end

  assign reg_rdata = {{RSV_W{1'b0}}, flag_q, en_q};

  // R4
  trig_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> trig_out);
  // R4
  trig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |=> !trig_out);
  // R2
  one_hit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_hit |-> (($countones(ch_hit_vec & ~ch_en)) == 0));
  // R3
  init_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_hit && !ch_hit && !flag_q) |=> !flag_q);
  // R10
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_hit && reg_wr && !reg_wdata[FLAG_BIT]) |=> flag_q);
  // R11
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[EN_W-1:0] == $past(reg_wdata[EN_W-1:0]));
  // R11
  reserved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (|reg_wdata[REG_W-1:CTRL_W])) |=> reg_rdata[REG_W-1:CTRL_W] == '0);
  // R6
  clear_only_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |-> armed_q);
endmodule

// File: tb/trig_match_gen_bench.sv
module trig_match_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic [CW-1:0] init_val = '0;
  logic [CW-1:0] cmp [NC];
  logic [NC*CW-1:0] cmp_flat;
  logic          reg_rd = 1'b0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          trig_out;

  always_comb
    for (int i = 0; i < NC; i++) cmp_flat[i*CW +: CW] = cmp[i];

  trig_match_gen #(.CNT_W(CW)) u_trig_match_gen (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .init_val(init_val),
    .cmp_vals(cmp_flat), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_out(trig_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    vec_cnt = 0;
  int    bad_cnt = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  bit [6:0] m_en;
  bit       m_flag, m_armed, m_trig;

  function automatic int en_bit(input int ch);
    case (ch)
      0: return 4;
      1: return 5;
      2: return 0;
      3: return 1;
      4: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic compare(input string req, input string what, input longint act, input longint exp);
    vec_cnt++;
    if (act != exp) begin
      bad_cnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit chh = 0;
    bit inh;
    for (int i = 0; i < NC; i++)
      if (m_en[en_bit(i)] && cnt_val == cmp[i]) chh = 1;
    inh = m_en[6] && (cnt_val == init_val);
    m_trig = chh || inh;
    if (chh) begin
      m_flag = 1; m_armed = 0;
    end else begin
      if (reg_wr && m_armed && !reg_wdata[7]) m_flag = 0;
      if (reg_wr) m_armed = 0;
      else if (reg_rd && m_flag) m_armed = 1;
    end
    if (reg_wr) m_en = reg_wdata[6:0];
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag, "trig_out", trig_out, m_trig);
    compare(tag, "reg_rdata", reg_rdata, {24'h0, m_flag, m_en});
    reg_rd = 0;
    reg_wr = 0;
  endtask

  task automatic do_wr(input logic [31:0] v);
    reg_wr = 1; reg_wdata = v; tick();
  endtask

  task automatic do_rd();
    reg_rd = 1; tick();
  endtask

  task automatic sweep(input int lo, input int hi);
    for (int c = lo; c <= hi; c++) begin
      cnt_val = CW'(c); tick();
    end
  endtask

  initial begin
    for (int i = 0; i < NC; i++) cmp[i] = CW'(200 + i);
    m_en = '0; m_flag = 0; m_armed = 0; m_trig = 0;
    cnt_val = CW'(500);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    compare("R1", "reset reg_rdata", reg_rdata, 0);
    compare("R1", "reset trig_out", trig_out, 0);

    // R2 each channel alone; all compare values present, one enabled
    tag = "R2";
    for (int ch = 0; ch < NC; ch++) begin
      for (int i = 0; i < NC; i++) cmp[i] = CW'(i + 3);
      do_wr(32'h1 << en_bit(ch));
      sweep(0, 10);
    end
    // clear the flag the channel tests left set
    cnt_val = CW'(500);
    do_rd(); do_wr(0);

    // R3 init trigger alone: pulses, flag stays 0
    tag = "R3";
    init_val = CW'(5);
    do_wr(32'h40);
    sweep(0, 8);

    // R4 simultaneous and back-to-back matches
    tag = "R4";
    for (int i = 0; i < NC; i++) cmp[i] = CW'(4);
    init_val = CW'(4);
    do_wr(32'h7f);
    sweep(0, 6);
    cmp[0] = CW'(6); cmp[1] = CW'(7);
    sweep(5, 9);

    // R6 read then clear
    tag = "R6";
    cnt_val = CW'(500);
    do_rd(); do_wr(32'h3f);
    // set again by a channel match (R5)
    tag = "R5";
    cnt_val = CW'(4); tick();
    cnt_val = CW'(500); tick();

    // R7 writes of 1, and 0 without an armed read
    tag = "R7";
    do_wr(32'hbf); do_wr(32'h3f);
    do_rd(); do_wr(32'hbf);
    // R8 the write of 1 consumed the arm; this 0 must not clear
    tag = "R8";
    do_wr(32'h3f);

    // R9 channel match between read and write
    tag = "R9";
    do_rd();
    cnt_val = CW'(4); tick();
    cnt_val = CW'(500);
    do_wr(32'h3f);
    // R6 plain sequence now clears
    tag = "R6";
    do_rd(); do_wr(32'h3f);

    // R10 clearing write in the same cycle as a channel match
    tag = "R10";
    cnt_val = CW'(4); tick();
    cnt_val = CW'(500);
    do_rd();
    cnt_val = CW'(4); do_wr(32'h3f);
    cnt_val = CW'(500); tick();

    // R11 reserved bits ignored; enables take effect next clock
    tag = "R11";
    do_rd(); do_wr(32'hffffff00);
    cmp[2] = CW'(9);
    cnt_val = CW'(9); do_wr(32'h01);
    tick();
    cnt_val = CW'(500); tick();
    do_wr(32'h5a5a5a00);

    // random mix, every cycle compared against the model
    tag = "R5";
    for (int n = 0; n < 4000; n++) begin
      cnt_val  = CW'($urandom_range(0, 7));
      init_val = CW'($urandom_range(0, 7));
      for (int i = 0; i < NC; i++) cmp[i] = CW'($urandom_range(0, 12));
      reg_rd = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 5) == 0) begin
        reg_wr = 1; reg_wdata = $urandom();
      end
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad_cnt++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end
endmodule